// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers of a processor core whose visible register set depends on the current privilege mode. A 5-bit mode field picks which physical copy each 4-bit architectural register number reaches: the low eight registers are common to all modes. The fast-interrupt mode keeps private copies of r8 to r12. Each exception mode keeps its own r13 and r14. The block serves two combinational read ports and one clocked write port.

Privileged code can ask for another mode's banked stack and link registers through a cross-mode override. Each exception mode also has one saved-status register, reached through a separate read/write port that follows the current mode. The program counter, the current status register and instruction decode live outside the block. An illegal mode encoding raises a sticky fault flag.

Top module: `banked_regfile`

## Requirements
- R1: Registers r0 to r7 reach one physical copy that is shared by every valid mode.
- R2: In fiq mode, r8 to r12 reach a private copy. Every other valid mode shares one common copy of r8 to r12.
- R3: Mode encodings are usr=5'b10000, fiq=5'b10001, irq=5'b10010, svc=5'b10011, abt=5'b10111, und=5'b11011 and sys=5'b11111. The svc, abt, und, irq and fiq modes each have a private r13 and r14. The usr and sys modes share one r13 and r14.
- R4: Register number 15 is not held here. Reads of it return zero and writes to it are discarded.
- R5: When `xmode_en_i` is high, the current mode is privileged (valid and not usr) and `xmode_i` is a valid encoding, r13 and r14 on all three ports reach the banked copy of `xmode_i`. In usr mode, or when `xmode_i` is illegal, the override is ignored. The override never changes which copy of r8 to r12 is used.
- R6: svc, abt, und, irq and fiq each own one saved-status register, read and written through the `sv_*` ports according to the current mode. In usr and sys mode the saved-status read returns zero and writes are discarded.
- R7: Any mode encoding other than the seven valid ones drives `mode_fault_o` high from the next clock edge onward, and only reset clears it. While the mode is illegal, all reads return zero and all writes are discarded.
- R8: Reads are combinational. A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: Reset clears every general register, every saved-status register and the fault flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 5 | Current processor mode |
| xmode_en_i | input | 1 | Enable cross-mode access to r13/r14 |
| xmode_i | input | 5 | Mode whose r13/r14 are reached under override |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_addr_i | input | 4 | Write register number |
| wr_data_i | input | 32 | Write data |
| sv_wr_en_i | input | 1 | Saved-status write enable |
| sv_wr_data_i | input | 32 | Saved-status write data |
| sv_rd_data_o | output | 32 | Saved-status read data for current mode |
| mode_fault_o | output | 1 | Sticky illegal-mode flag |

## Verification
The bench builds the block at its default 32-bit data width. At that width, all seven valid modes times all sixteen register numbers on both read ports can be swept after a write pass that stamps every value with its writing mode and register number. Because each value is stamped, any wrong bank selection shows up as a wrong stamp. The override matrix, the saved-status bank in every mode, the same-cycle read-during-write and an illegal encoding with its sticky flag are each checked at their own cycle boundaries.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned N_SHARED = 8;
  localparam int unsigned N_HI     = 5;
  localparam int unsigned N_BANKS  = 6;
  localparam int unsigned FIQ_BASE = N_SHARED + N_HI;
  localparam int unsigned SP_BASE  = FIQ_BASE + N_HI;
  localparam int unsigned N_PHYS   = SP_BASE + 2 * N_BANKS;
  localparam int unsigned PHYS_W   = $clog2(N_PHYS);
  localparam int unsigned N_SV     = 5;
  localparam int unsigned SV_W     = $clog2(N_SV);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  function automatic logic mode_valid(logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_priv(logic [MODE_W-1:0] m);
    return mode_valid(m) && (m != M_USR);
  endfunction

  // r13/r14 bank: usr and sys share bank 0
  function automatic int unsigned sp_bank(logic [MODE_W-1:0] m);
    case (m)
      M_SVC:   return 1;
      M_ABT:   return 2;
      M_UND:   return 3;
      M_IRQ:   return 4;
      M_FIQ:   return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic has_sv(logic [MODE_W-1:0] m);
    return mode_priv(m) && (m != M_SYS);
  endfunction
endpackage

// File: rtl/brf_map.sv
module brf_map
  import brf_pkg::*;
(
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [MODE_W-1:0] bank_mode_i,
  output logic              hit_o,
  output logic [PHYS_W-1:0] idx_o
);
  int unsigned r;

  always_comb begin
    r     = int'(reg_i);
    hit_o = 1'b0;
    idx_o = '0;
    if (mode_valid(mode_i)) begin
      if (r < N_SHARED) begin
        hit_o = 1'b1;
        idx_o = PHYS_W'(r);
      end else if (r < N_SHARED + N_HI) begin
        hit_o = 1'b1;
        idx_o = (mode_i == M_FIQ) ? PHYS_W'(FIQ_BASE + r - N_SHARED) : PHYS_W'(r);
      end else if (r < N_SHARED + N_HI + 2) begin
        hit_o = 1'b1;
        idx_o = PHYS_W'(SP_BASE + 2 * sp_bank(bank_mode_i) + (r - N_SHARED - N_HI));
      end
    end
  end
endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 30,
  parameter int unsigned RD_PORTS = 2,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [IDX_W-1:0]                 w_idx_i,
  input  logic [DATA_W-1:0]                w_data_i,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]   r_idx_i,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  r_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[w_idx_i] <= w_data_i;
    end
  end

  for (genvar g = 0; g < int'(RD_PORTS); g++) begin : g_rd
    assign r_data_o[g] = mem[r_idx_i[g]];
  end

  // R8: write is visible from the next cycle
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(w_idx_i)] == $past(w_data_i));
endmodule

// File: rtl/brf_sv.sv
module brf_sv
  import brf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] sv_q [N_SV];
  logic [SV_W-1:0]   slot;
  logic              present;

  assign present = has_sv(mode_i);
  assign slot    = SV_W'(sp_bank(mode_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_SV); i++) sv_q[i] <= '0;
    end else if (we_i && present) begin
      sv_q[slot] <= wd_i;
    end
  end

  assign rd_o = present ? sv_q[slot] : '0;

  // R6: no saved-status in usr or sys
  a_r6_no_sv_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_USR || mode_i == M_SYS) |-> rd_o == '0);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              xmode_en_i,
  input  logic [4:0]        xmode_i,
  input  logic [3:0]        rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sv_wr_en_i,
  input  logic [DATA_W-1:0] sv_wr_data_i,
  output logic [DATA_W-1:0] sv_rd_data_o,
  output logic              mode_fault_o
);
  localparam int unsigned N_PORT = 3; // 0: read A, 1: read B, 2: write

  logic [MODE_W-1:0]                bank_mode;
  logic [N_PORT-1:0][ADDR_W-1:0]    p_addr;
  logic [N_PORT-1:0]                p_hit;
  logic [N_PORT-1:0][PHYS_W-1:0]    p_idx;
  logic [1:0][DATA_W-1:0]           r_data;
  logic                             fault_q;

  assign bank_mode = (xmode_en_i && mode_priv(mode_i) && mode_valid(xmode_i)) ? xmode_i : mode_i;
  assign p_addr    = {wr_addr_i, rd_b_addr_i, rd_a_addr_i};

  for (genvar g = 0; g < int'(N_PORT); g++) begin : g_map
    brf_map u_map (
      .reg_i      (p_addr[g]),
      .mode_i     (mode_i),
      .bank_mode_i(bank_mode),
      .hit_o      (p_hit[g]),
      .idx_o      (p_idx[g])
    );
  end

  brf_store #(
    .DATA_W  (DATA_W),
    .DEPTH   (N_PHYS),
    .RD_PORTS(2)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && p_hit[2]),
    .w_idx_i (p_idx[2]),
    .w_data_i(wr_data_i),
    .r_idx_i (p_idx[1:0]),
    .r_data_o(r_data)
  );

  assign rd_a_data_o = p_hit[0] ? r_data[0] : '0;
  assign rd_b_data_o = p_hit[1] ? r_data[1] : '0;

  brf_sv #(.DATA_W(DATA_W)) u_sv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .we_i  (sv_wr_en_i),
    .wd_i  (sv_wr_data_i),
    .rd_o  (sv_rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else if (!mode_valid(mode_i)) fault_q <= 1'b1;
  end
  assign mode_fault_o = fault_q;

  a_r7_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_fault_o |=> mode_fault_o);
  a_r7_fault_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_valid(mode_i) |=> mode_fault_o);
  a_r4_pc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == 4'd15) |-> rd_a_data_o == '0);
  a_r7_illegal_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_valid(mode_i) |-> (rd_b_data_o == '0 && sv_rd_data_o == '0));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;
  localparam logic [4:0] MODES [7] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};

  logic clk_i = 0, rst_ni = 0;
  logic [4:0] mode_i = USR, xmode_i = USR;
  logic xmode_en_i = 0, wr_en_i = 0, sv_wr_en_i = 0;
  logic [3:0] rd_a_addr_i = 0, rd_b_addr_i = 0, wr_addr_i = 0;
  logic [31:0] wr_data_i = 0, sv_wr_data_i = 0;
  logic [31:0] rd_a_data_o, rd_b_data_o, sv_rd_data_o;
  logic mode_fault_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  banked_regfile uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stamp(logic [4:0] m, int r);
    return 32'hC000_0000 | (32'(m) << 8) | 32'(r);
  endfunction

  // value after the write pass (modes written in MODES order, sys last)
  function automatic logic [31:0] exp_val(logic [4:0] m, int r);
    if (r == 15) return '0;
    if (r < 8) return stamp(SYS, r);
    if (r < 13) return (m == FIQ) ? stamp(FIQ, r) : stamp(SYS, r);
    return (m == USR || m == SYS) ? stamp(SYS, r) : stamp(m, r);
  endfunction

  task automatic wr(logic [4:0] m, logic xe, logic [4:0] xm, int r, logic [31:0] v);
    @(negedge clk_i);
    mode_i = m; xmode_en_i = xe; xmode_i = xm;
    wr_addr_i = 4'(r); wr_data_i = v; wr_en_i = 1;
    @(negedge clk_i);
    wr_en_i = 0; xmode_en_i = 0;
  endtask

  task automatic rd(logic [4:0] m, logic xe, logic [4:0] xm, int ra, int rb);
    @(negedge clk_i);
    mode_i = m; xmode_en_i = xe; xmode_i = xm;
    rd_a_addr_i = 4'(ra); rd_b_addr_i = 4'(rb);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk_i); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    rst_ni = 1;
    // R9: reset state everywhere
    chk("R9 fault after reset", 32'(mode_fault_o), 0);
    foreach (MODES[i]) begin
      for (int r = 0; r < 16; r++) begin
        rd(MODES[i], 0, USR, r, 15 - r);
        chk("R9 reset reg A", rd_a_data_o, 0);
        chk("R9 reset reg B", rd_b_data_o, 0);
      end
      chk("R9 reset saved-status", sv_rd_data_o, 0);
    end

    // write pass: every mode stamps r0..r15
    foreach (MODES[i])
      for (int r = 0; r < 16; r++) wr(MODES[i], 0, USR, r, stamp(MODES[i], r));

    // R1 R2 R3 R4: full sweep, both ports
    foreach (MODES[i])
      for (int r = 0; r < 16; r++) begin
        rd(MODES[i], 0, USR, r, 15 - r);
        if (r < 8)       chk("R1 shared low regs", rd_a_data_o, exp_val(MODES[i], r));
        else if (r < 13) chk("R2 r8-r12 banking", rd_a_data_o, exp_val(MODES[i], r));
        else if (r < 15) chk("R3 r13/r14 banking", rd_a_data_o, exp_val(MODES[i], r));
        else             chk("R4 r15 reads zero", rd_a_data_o, 0);
        chk("R3 port B sweep", rd_b_data_o, exp_val(MODES[i], 15 - r));
      end

    // R5: cross-mode override
    rd(SVC, 1, IRQ, 13, 14);
    chk("R5 svc reads irq r13", rd_a_data_o, stamp(IRQ, 13));
    chk("R5 svc reads irq r14", rd_b_data_o, stamp(IRQ, 14));
    rd(USR, 1, SVC, 13, 14);
    chk("R5 usr override ignored r13", rd_a_data_o, stamp(SYS, 13));
    chk("R5 usr override ignored r14", rd_b_data_o, stamp(SYS, 14));
    rd(SVC, 1, 5'b00101, 13, 8);
    chk("R5 illegal target ignored", rd_a_data_o, stamp(SVC, 13));
    chk("R5 no effect on r8", rd_b_data_o, stamp(SYS, 8));
    rd(SVC, 1, FIQ, 9, 13);
    chk("R5 fiq override leaves r9", rd_a_data_o, stamp(SYS, 9));
    chk("R5 fiq override reaches r13", rd_b_data_o, stamp(FIQ, 13));
    wr(SVC, 1, ABT, 14, 32'h1234_5678);
    rd(ABT, 0, USR, 14, 14);
    chk("R5 override write lands in abt", rd_a_data_o, 32'h1234_5678);
    rd(SVC, 0, USR, 14, 13);
    chk("R5 svc r14 untouched", rd_a_data_o, stamp(SVC, 14));
    wr(USR, 1, FIQ, 13, 32'h8765_4321);
    rd(FIQ, 0, USR, 13, 13);
    chk("R5 usr override write ignored", rd_a_data_o, stamp(FIQ, 13));
    rd(SYS, 0, USR, 13, 13);
    chk("R5 usr write lands in own r13", rd_a_data_o, 32'h8765_4321);

    // R4: r15 write discarded
    wr(SVC, 0, USR, 15, 32'hFFFF_FFFF);
    rd(SVC, 0, USR, 15, 14);
    chk("R4 r15 write discarded", rd_a_data_o, 0);
    chk("R4 r14 not hit", rd_b_data_o, stamp(SVC, 14));

    // R6: saved-status bank
    foreach (MODES[i]) begin
      @(negedge clk_i);
      mode_i = MODES[i]; sv_wr_data_i = 32'h5000_0000 | 32'(MODES[i]); sv_wr_en_i = 1;
      @(negedge clk_i); sv_wr_en_i = 0;
    end
    foreach (MODES[i]) begin
      rd(MODES[i], 0, USR, 0, 0);
      if (MODES[i] == USR || MODES[i] == SYS) chk("R6 no saved-status", sv_rd_data_o, 0);
      else chk("R6 saved-status per mode", sv_rd_data_o, 32'h5000_0000 | 32'(MODES[i]));
    end

    // R8: read during write returns old
    @(negedge clk_i);
    mode_i = IRQ; rd_a_addr_i = 4'd3; wr_addr_i = 4'd3; wr_data_i = 32'hABCD_0003; wr_en_i = 1;
    #1 chk("R8 same-cycle old value", rd_a_data_o, stamp(SYS, 3));
    @(posedge clk_i); #1;
    chk("R8 new value after edge", rd_a_data_o, 32'hABCD_0003);
    @(negedge clk_i); wr_en_i = 0;

    // R7: illegal mode
    chk("R7 no fault yet", 32'(mode_fault_o), 0);
    @(negedge clk_i);
    mode_i = 5'b00000; rd_a_addr_i = 4'd1; rd_b_addr_i = 4'd13;
    wr_addr_i = 4'd1; wr_data_i = 32'hDEAD_BEEF; wr_en_i = 1;
    sv_wr_data_i = 32'hDEAD_0000; sv_wr_en_i = 1;
    #1;
    chk("R7 illegal read A zero", rd_a_data_o, 0);
    chk("R7 illegal read B zero", rd_b_data_o, 0);
    chk("R7 fault rises next edge", 32'(mode_fault_o), 0);
    @(posedge clk_i); #1;
    chk("R7 fault set", 32'(mode_fault_o), 1);
    @(negedge clk_i); wr_en_i = 0; sv_wr_en_i = 0; mode_i = USR;
    rd(USR, 0, USR, 1, 13);
    chk("R7 illegal write discarded", rd_a_data_o, stamp(SYS, 1));
    rd(SVC, 0, USR, 0, 0);
    chk("R7 illegal sv write discarded", sv_rd_data_o, 32'h5000_0000 | 32'(SVC));
    repeat (4) @(negedge clk_i);
    chk("R7 fault sticky", 32'(mode_fault_o), 1);

    // R9: reset clears fault and storage
    do_reset();
    rd(USR, 0, USR, 1, 13);
    chk("R9 fault cleared", 32'(mode_fault_o), 0);
    chk("R9 r1 cleared", rd_a_data_o, 0);
    chk("R9 r13 cleared", rd_b_data_o, 0);
    rd(SVC, 0, USR, 14, 0);
    chk("R9 saved-status cleared", sv_rd_data_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule